// File: doc/BRIEF.md
# Target read response adapter

This block sits between a host-side target read request port and a 32-bit register or memory backend. Each accepted request carries a dword address, eight quadword-aligned byte enables, a 4-bit tag and an 8-bit control byte. The adapter turns a request into one or two dword reads on the backend. Its byte strobes are taken from the enables, so bytes that were not requested are never touched on a side-effecting backend. When the data is back, it returns one quadword-aligned 64-bit response with the tag and control byte attached.

Accepted requests wait in a small in-order queue. Bit 0 of the control byte decides whether both dwords of the quadword are read. When it is clear, the requested dword is read and placed in the half of the response that matches address bit 0. The backend is a plain synchronous read port whose data arrives a fixed number of cycles (`RD_LAT`) after the read is issued.

Top module: `tgt_rd_adapter`

## Requirements
- R1: After reset `rsp_vld_o` and `mem_en_o` are low and `req_rdy_o` is high. A request is taken in a cycle where `req_en_i` and `req_rdy_o` are both high.
- R2: Up to `FIFO_DEPTH` (default 4) accepted requests may be waiting to issue. `req_rdy_o` is low exactly while that many are held.
- R3: With control bit 0 set, two backend reads are issued in consecutive cycles: first the even dword of the quadword (`mem_addr_o[0]`=0), then the odd one. The response carries the odd dword in `rsp_data_o[63:32]` and the even dword in `rsp_data_o[31:0]`.
- R4: With control bit 0 clear and `req_addr_i[0]`=0, one read of that dword is issued. Its data appears in `rsp_data_o[31:0]` and `rsp_data_o[63:32]` is zero.
- R5: With control bit 0 clear and `req_addr_i[0]`=1, one read of that dword is issued. Its data appears in `rsp_data_o[63:32]` and `rsp_data_o[31:0]` is zero.
- R6: Enable bit k covers response byte k (bits 8k+7:8k). The strobe is `req_be_i[3:0]` for the even dword and `req_be_i[7:4]` for the odd one. Response bytes whose enable is clear are zero. For example, dword address 2 with enables 0x3C and control bit 0 set returns bytes 2..5 of the quadword.
- R7: `rsp_tag_o` and `rsp_ctrl_o` equal the tag and the full control byte of the request being answered.
- R8: Responses come back in acceptance order. Each response is a single-cycle `rsp_vld_o` pulse, `RD_LAT`+1 cycles after its last backend read is issued. Backend reads are issued back to back whenever a request is waiting.
- R9: Control bit 0 is only set on requests whose `req_addr_i[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_en_i | input | 1 | Request present |
| req_addr_i | input | 30 | Dword address of the request |
| req_be_i | input | 8 | Quadword-aligned byte enables |
| req_tag_i | input | 4 | Request tag |
| req_ctrl_i | input | 8 | Control byte; bit 0 asks for both dwords |
| req_rdy_o | output | 1 | Request can be taken |
| mem_en_o | output | 1 | Backend read strobe |
| mem_addr_o | output | 30 | Backend dword address |
| mem_strb_o | output | 4 | Backend byte strobes |
| mem_rdata_i | input | 32 | Backend read data, `RD_LAT` cycles after `mem_en_o` |
| rsp_vld_o | output | 1 | Response valid pulse |
| rsp_data_o | output | 64 | Quadword-aligned response data |
| rsp_tag_o | output | 4 | Echoed tag |
| rsp_ctrl_o | output | 8 | Echoed control byte |

## Verification
The assertions rely on the requester never setting control bit 0 together with address bit 0. They also rely on backend data being valid exactly `RD_LAT` cycles after each read. The bench builds its control bytes so that bit 0 is only set for even dword addresses, and this holds in the directed cases as well as the random ones. Its behavioural backend returns data on exactly that latency and places junk on the data bus in every other cycle. Because of that junk, any mis-timed capture shows up as a data mismatch.

// File: rtl/tra_pkg.sv
package tra_pkg;
  parameter int unsigned DW_ADDR_W = 30;
  parameter int unsigned TAG_W     = 4;
  parameter int unsigned CTRL_W    = 8;
  localparam int unsigned LANE_W   = 4;
  localparam int unsigned BE_W     = 2 * LANE_W;
  localparam int unsigned DWORD_W  = 8 * LANE_W;
  localparam int unsigned QWORD_W  = 2 * DWORD_W;

  typedef struct packed {
    logic [DW_ADDR_W-1:0] addr;
    logic [BE_W-1:0]      be;
    logic [TAG_W-1:0]     tag;
    logic [CTRL_W-1:0]    ctrl;
  } req_t;

  // one backend read in flight
  typedef struct packed {
    logic              pair;
    logic              hi;
    logic              last;
    logic [LANE_W-1:0] strb;
    logic [TAG_W-1:0]  tag;
    logic [CTRL_W-1:0] ctrl;
  } beat_t;
endpackage

// File: rtl/tra_req_fifo.sv
module tra_req_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R8
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R2
endmodule

// File: rtl/tra_issue.sv
module tra_issue
  import tra_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  req_t                 head_i,
  input  logic                 empty_i,
  output logic                 pop_o,
  output logic                 mem_en_o,
  output logic [DW_ADDR_W-1:0] mem_addr_o,
  output logic [LANE_W-1:0]    mem_strb_o,
  output beat_t                beat_o
);
  logic sec_q;
  logic pair, hi, last;

  always_comb begin
    pair       = head_i.ctrl[0];
    hi         = pair ? sec_q : head_i.addr[0];
    last       = !pair || sec_q;
    mem_en_o   = !empty_i;
    pop_o      = !empty_i && last;
    mem_addr_o = {head_i.addr[DW_ADDR_W-1:1], hi};
    mem_strb_o = hi ? head_i.be[BE_W-1:LANE_W] : head_i.be[LANE_W-1:0];
    beat_o     = '{pair: pair, hi: hi, last: last, strb: mem_strb_o,
                   tag: head_i.tag, ctrl: head_i.ctrl};
  end

  // second half of a pair follows in the next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sec_q <= 1'b0;
    else if (!empty_i && pair)  sec_q <= !sec_q;
  end

  AST_PAIR_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q |-> (!empty_i && head_i.ctrl[0])); // R3
  AST_POP_ONLY_AFTER_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && head_i.ctrl[0]) |-> $past(mem_en_o && !pop_o)); // R3
endmodule

// File: rtl/tra_rsp_asm.sv
module tra_rsp_asm
  import tra_pkg::*;
#(
  parameter int unsigned RD_LAT = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_i,
  input  beat_t              beat_i,
  input  logic [DWORD_W-1:0] rdata_i,
  output logic               rsp_vld_o,
  output logic [QWORD_W-1:0] rsp_data_o,
  output logic [TAG_W-1:0]   rsp_tag_o,
  output logic [CTRL_W-1:0]  rsp_ctrl_o
);
  // latency-matched pipeline of beat descriptors
  for (genvar gi = 0; gi < RD_LAT; gi++) begin : g_stage
    logic  v_d, v_q;
    beat_t b_d, b_q;
    if (gi == 0) begin : g_head
      assign v_d = issue_i;
      assign b_d = beat_i;
    end else begin : g_tail
      assign v_d = g_stage[gi-1].v_q;
      assign b_d = g_stage[gi-1].b_q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        b_q <= '0;
      end else begin
        v_q <= v_d;
        b_q <= b_d;
      end
    end
  end

  logic               ret_vld;
  beat_t              ret;
  logic [DWORD_W-1:0] lane_mask, masked;
  logic [DWORD_W-1:0] acc_lo_q;

  assign ret_vld = g_stage[RD_LAT-1].v_q;
  assign ret     = g_stage[RD_LAT-1].b_q;

  for (genvar gb = 0; gb < LANE_W; gb++) begin : g_lane
    assign lane_mask[gb*8 +: 8] = {8{ret.strb[gb]}};
  end
  assign masked = rdata_i & lane_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_vld_o  <= 1'b0;
      rsp_data_o <= '0;
      rsp_tag_o  <= '0;
      rsp_ctrl_o <= '0;
      acc_lo_q   <= '0;
    end else begin
      rsp_vld_o <= ret_vld && ret.last;
      if (ret_vld && !ret.last) acc_lo_q <= masked;
      if (ret_vld && ret.last) begin
        if (ret.pair)    rsp_data_o <= {masked, acc_lo_q};
        else if (ret.hi) rsp_data_o <= {masked, {DWORD_W{1'b0}}};
        else             rsp_data_o <= {{DWORD_W{1'b0}}, masked};
        rsp_tag_o  <= ret.tag;
        rsp_ctrl_o <= ret.ctrl;
      end
    end
  end

  AST_RSP_FROM_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o |-> $past(ret_vld && ret.last)); // R8
  AST_NONLAST_IS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_vld && !ret.last) |-> (ret.pair && !ret.hi)); // R3
  AST_LO_BEFORE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_vld && ret.pair && ret.hi) |-> $past(ret_vld && ret.pair && !ret.hi)); // R3
  AST_PAIR_SAME_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_vld && ret.pair && ret.hi) |-> (ret.tag == $past(ret.tag) && ret.ctrl == $past(ret.ctrl))); // R7
endmodule

// File: rtl/tgt_rd_adapter.sv
module tgt_rd_adapter
  import tra_pkg::*;
#(
  parameter int unsigned RD_LAT     = 2,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_en_i,
  input  logic [DW_ADDR_W-1:0] req_addr_i,
  input  logic [BE_W-1:0]      req_be_i,
  input  logic [TAG_W-1:0]     req_tag_i,
  input  logic [CTRL_W-1:0]    req_ctrl_i,
  output logic                 req_rdy_o,
  output logic                 mem_en_o,
  output logic [DW_ADDR_W-1:0] mem_addr_o,
  output logic [LANE_W-1:0]    mem_strb_o,
  input  logic [DWORD_W-1:0]   mem_rdata_i,
  output logic                 rsp_vld_o,
  output logic [QWORD_W-1:0]   rsp_data_o,
  output logic [TAG_W-1:0]     rsp_tag_o,
  output logic [CTRL_W-1:0]    rsp_ctrl_o
);
  localparam int unsigned REQ_W = $bits(req_t);

  logic             push, pop, full, empty;
  logic [REQ_W-1:0] wr_vec, rd_vec;
  req_t             head;
  beat_t            beat;

  assign req_rdy_o = !full;
  assign push      = req_en_i && req_rdy_o;
  assign wr_vec    = {req_addr_i, req_be_i, req_tag_i, req_ctrl_i};
  assign head      = req_t'(rd_vec);

  tra_req_fifo #(.WIDTH(REQ_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wr_vec),
    .pop_i   (pop),
    .rdata_o (rd_vec),
    .full_o  (full),
    .empty_o (empty)
  );

  tra_issue u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .head_i     (head),
    .empty_i    (empty),
    .pop_o      (pop),
    .mem_en_o   (mem_en_o),
    .mem_addr_o (mem_addr_o),
    .mem_strb_o (mem_strb_o),
    .beat_o     (beat)
  );

  tra_rsp_asm #(.RD_LAT(RD_LAT)) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (mem_en_o),
    .beat_i     (beat),
    .rdata_i    (mem_rdata_i),
    .rsp_vld_o  (rsp_vld_o),
    .rsp_data_o (rsp_data_o),
    .rsp_tag_o  (rsp_tag_o),
    .rsp_ctrl_o (rsp_ctrl_o)
  );

  AST_PAIR_EVEN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_en_i && req_rdy_o && req_ctrl_i[0]) |-> !req_addr_i[0]); // R9
  AST_ISSUE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_en_i && req_rdy_o && !mem_en_o) |=> mem_en_o); // R8
endmodule

// File: tb/tgt_rd_adapter_test.sv
`timescale 1ns/1ps
module tgt_rd_adapter_test;
  localparam int RD_LAT = 2;
  localparam int DEPTH  = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_en_i;
  logic [29:0] req_addr_i;
  logic [7:0]  req_be_i;
  logic [3:0]  req_tag_i;
  logic [7:0]  req_ctrl_i;
  logic        req_rdy_o;
  logic        mem_en_o;
  logic [29:0] mem_addr_o;
  logic [3:0]  mem_strb_o;
  logic [31:0] mem_rdata_i;
  logic        rsp_vld_o;
  logic [63:0] rsp_data_o;
  logic [3:0]  rsp_tag_o;
  logic [7:0]  rsp_ctrl_o;

  tgt_rd_adapter #(.RD_LAT(RD_LAT), .FIFO_DEPTH(DEPTH)) uut (.*);

  always #2.5 clk_i = ~clk_i;

  int errors = 0, checks = 0, cyc = 0, occ = 0;
  bit run = 0, saw_full = 0, done = 0;

  // expected backend accesses
  logic [29:0] ea_q[$];
  logic [3:0]  es_q[$];
  bit          el_q[$];
  // backend return pipe
  int          bdue_q[$];
  logic [31:0] bdat_q[$];
  bit          blast_q[$];
  // expected responses
  int          rdue_q[$];
  logic [63:0] rdat_q[$];
  logic [3:0]  rtag_q[$];
  logic [7:0]  rctl_q[$];
  string       rreq_q[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [31:0] mem_val(input logic [29:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h6C3A_915E;
  endfunction

  function automatic logic [31:0] bmask(input logic [3:0] s);
    return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model, evaluated mid-cycle
  always @(negedge clk_i) if (run) begin
    bit exp_v, exp_en;
    exp_v = (rdue_q.size() > 0) && (rdue_q[0] == cyc);
    chk(rsp_vld_o == exp_v, "R8 rsp_vld", 64'(rsp_vld_o), 64'(exp_v));
    if (exp_v && rsp_vld_o) begin
      chk(rsp_data_o == rdat_q[0], rreq_q[0], rsp_data_o, rdat_q[0]);
      chk(rsp_tag_o == rtag_q[0], "R7 tag", 64'(rsp_tag_o), 64'(rtag_q[0]));
      chk(rsp_ctrl_o == rctl_q[0], "R7 ctrl", 64'(rsp_ctrl_o), 64'(rctl_q[0]));
    end
    if (exp_v) begin
      void'(rdue_q.pop_front()); void'(rdat_q.pop_front());
      void'(rtag_q.pop_front()); void'(rctl_q.pop_front()); void'(rreq_q.pop_front());
    end
    chk(req_rdy_o == (occ < DEPTH), "R2 req_rdy", 64'(req_rdy_o), 64'(occ < DEPTH));
    if (!req_rdy_o) saw_full = 1;
    if (bdue_q.size() > 0 && bdue_q[0] == cyc) begin
      mem_rdata_i = bdat_q.pop_front();
      void'(bdue_q.pop_front());
      if (blast_q.pop_front()) rdue_q.push_back(cyc + 1);
    end else begin
      mem_rdata_i = 32'hDEAD_BEEF;
    end
    exp_en = ea_q.size() > 0;
    chk(mem_en_o == exp_en, "R8 mem_en", 64'(mem_en_o), 64'(exp_en));
    if (mem_en_o && exp_en) begin
      logic [29:0] a; logic [3:0] s; bit l;
      a = ea_q.pop_front(); s = es_q.pop_front(); l = el_q.pop_front();
      chk(mem_addr_o == a, "R3 mem_addr", 64'(mem_addr_o), 64'(a));
      chk(mem_strb_o == s, "R6 mem_strb", 64'(mem_strb_o), 64'(s));
      bdue_q.push_back(cyc + RD_LAT);
      bdat_q.push_back(mem_val(mem_addr_o));
      blast_q.push_back(l);
      if (l) occ--;
    end
    if (req_en_i && req_rdy_o) begin
      logic [29:0] ev, od;
      ev = {req_addr_i[29:1], 1'b0};
      od = {req_addr_i[29:1], 1'b1};
      if (req_ctrl_i[0]) begin
        ea_q.push_back(ev); es_q.push_back(req_be_i[3:0]); el_q.push_back(0);
        ea_q.push_back(od); es_q.push_back(req_be_i[7:4]); el_q.push_back(1);
        rdat_q.push_back({mem_val(od) & bmask(req_be_i[7:4]), mem_val(ev) & bmask(req_be_i[3:0])});
        rreq_q.push_back("R3/R6 pair data");
      end else if (req_addr_i[0]) begin
        ea_q.push_back(od); es_q.push_back(req_be_i[7:4]); el_q.push_back(1);
        rdat_q.push_back({mem_val(od) & bmask(req_be_i[7:4]), 32'h0});
        rreq_q.push_back("R5/R6 upper data");
      end else begin
        ea_q.push_back(ev); es_q.push_back(req_be_i[3:0]); el_q.push_back(1);
        rdat_q.push_back({32'h0, mem_val(ev) & bmask(req_be_i[3:0])});
        rreq_q.push_back("R4/R6 lower data");
      end
      rtag_q.push_back(req_tag_i);
      rctl_q.push_back(req_ctrl_i);
      occ++;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic send(input logic [29:0] a, input logic [7:0] be, input logic [3:0] tg, input logic [7:0] c);
    bit took = 0;
    req_en_i = 1; req_addr_i = a; req_be_i = be; req_tag_i = tg; req_ctrl_i = c;
    while (!took) begin
      @(negedge clk_i); took = req_rdy_o;
      @(posedge clk_i); #1;
    end
    req_en_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_ni = 0; req_en_i = 0; req_addr_i = '0; req_be_i = '0;
    req_tag_i = '0; req_ctrl_i = '0; mem_rdata_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(rsp_vld_o == 0, "R1 reset rsp_vld", 64'(rsp_vld_o), 64'd0);
    chk(mem_en_o == 0, "R1 reset mem_en", 64'(mem_en_o), 64'd0);
    chk(req_rdy_o == 1, "R1 reset req_rdy", 64'(req_rdy_o), 64'd1);
    rst_ni = 1;
    run = 1;
    @(posedge clk_i); #1;
    send(30'h10, 8'h0F, 4'h1, 8'h00);  // R4
    send(30'h11, 8'hF0, 4'h2, 8'h00);  // R5
    send(30'h12, 8'hFF, 4'h3, 8'h01);  // R3
    send(30'h02, 8'h3C, 4'h4, 8'h01);  // R6 straddling bytes
    send(30'h14, 8'h00, 4'h5, 8'hA0);  // R6 no enables
    send(30'h15, 8'h30, 4'h6, 8'h5E);  // R7 echo, R6 partial
    send(30'h16, 8'hF0, 4'h7, 8'h00);  // R4 upper enables ignored on even dword
    idle(10);
    for (int i = 0; i < 12; i++) send(30'(32 + 2 * i), 8'hFF, 4'(i), 8'h81); // R2 fill
    idle(10);
    for (int i = 0; i < 400; i++) begin
      logic [29:0] a; logic [7:0] c;
      a = 30'($urandom_range(0, 4095));
      c = 8'($urandom);
      if (a[0]) c[0] = 1'b0;  // R9 legal requests only
      send(a, 8'($urandom), 4'($urandom), c);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(30);
    chk(rdue_q.size() == 0 && rdat_q.size() == 0 && ea_q.size() == 0,
        "R8 all answered in order", 64'(rdat_q.size()), 64'd0);
    chk(saw_full, "R2 queue filled", 64'(saw_full), 64'd1);
    finish_run();
  end
endmodule